// File: doc/BRIEF.md
# Two-bit burst address generator

This block supplies the word address for a synchronous burst SRAM. When a burst begins, it captures a full external address. On each later clock edge where the advance enable is asserted, it steps through four word addresses. Only the two lowest address bits change during the burst. The upper bits keep the value captured at the start.

A static order input selects one of two sequences for the low bits. In linear order they wrap-increment from the start value. In interleaved order they are the start value XOR a running step count. The default strap is interleaved.

The cycle decoder decides when a burst starts and whether the advance is requested, and that decision is outside this block. Dummy reads, which are reads with the output drivers off, are presented here as ordinary advances. The memory array and the data paths are also outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: After the asynchronous reset is released, `addr_o` and `step_o` are both zero.
- R2: When `load_i` is high at a clock edge, the following cycle shows `addr_o` equal to the `addr_i` sampled at that edge, with `step_o` equal to 0.
- R3: While `load_i` stays low, the bits of `addr_o` above bit 1 do not change.
- R4: With `order_i` = 0 (linear), `addr_o[1:0]` equals (start + `step_o`) mod 4, where start is bits [1:0] of the loaded address.
- R5: With `order_i` = 1 (interleaved), `addr_o[1:0]` equals start XOR `step_o`.
- R6: On an edge with `load_i` low, `step_o` increments by one mod 4 when `adv_ni` = 0, and holds its value when `adv_ni` = 1 (suspend).
- R7: After four advances from a load, `addr_o` returns to the loaded address in both orders.
- R8: A load can happen on any cycle, including back-to-back cycles and in the middle of a burst. Each one takes effect on the next cycle and discards the burst in progress.
- R9: When `load_i` and `adv_ni` = 0 occur on the same edge, the load wins and `step_o` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a burst: capture addr_i |
| addr_i | input | ADDR_W | External word address |
| adv_ni | input | 1 | Advance enable, active low |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_o | output | ADDR_W | Current word address |
| step_o | output | 2 | Position within the burst, 0 to 3 |

## Verification
The bench first runs directed bursts from every start value in both orders. These separate the linear wrap from the XOR pattern: the two orders agree for starts 00 and 10 on the first step, and they diverge for starts 01 and 11.

A second group of directed cases covers four consecutive advances (wrap to start), loads issued mid-burst and back-to-back, and a load applied together with an advance. Together these establish load priority and the absence of any load latency.

Constrained random traffic then mixes loads, suspends and order flips. Over long runs this catches a hold that leaks or upper bits that drift.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  localparam int unsigned LOW_W = 2;

  // Low address bits for a given start value and step count
  function automatic logic [LOW_W-1:0] burst_low(
    input logic [LOW_W-1:0] start,
    input logic [LOW_W-1:0] step,
    input burst_order_e     ord
  );
    if (ord == ORD_INTERLEAVE) return start ^ step;
    return LOW_W'(start + step);
  endfunction

endpackage

// File: rtl/burst_step_ctr.sv
module burst_step_ctr
  import burst_addr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_ni,
  output logic [LOW_W-1:0] step_o
);

  logic [LOW_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      step_q <= '0;
    else if (load_i)  step_q <= '0;               // load beats advance
    else if (!adv_ni) step_q <= step_q + 1'b1;    // wraps after four
  end

  assign step_o = step_q;

  p_load_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> step_o == '0);

  p_adv_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni) |=> step_o == LOW_W'($past(step_o) + 1'b1));

  p_suspend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> $stable(step_o));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);

  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (load_i) base_q <= addr_i;
  end

  assign base_o = base_q;

endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_addr_pkg::*;
(
  input  logic [LOW_W-1:0] start_i,
  input  logic [LOW_W-1:0] step_i,
  input  logic             order_i,
  output logic [LOW_W-1:0] low_o
);

  assign low_o = burst_low(start_i, step_i, burst_order_e'(order_i));

  always_comb begin
    if (step_i == '0) a_step0_start_r7: assert (low_o == start_i);
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_ni,
  input  logic              order_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        step_o
);

  localparam int unsigned HI_W = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] base;
  logic [LOW_W-1:0]  step;
  logic [LOW_W-1:0]  low;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .addr_i(addr_i),
    .base_o(base)
  );

  burst_step_ctr u_step (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .adv_ni(adv_ni),
    .step_o(step)
  );

  burst_low_map u_map (
    .start_i(base[LOW_W-1:0]),
    .step_i (step),
    .order_i(order_i),
    .low_o  (low)
  );

  assign addr_o = {base[ADDR_W-1:LOW_W], low};
  assign step_o = step;

  p_load_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i));

  p_upper_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> addr_o[ADDR_W-1 -: HI_W] == $past(addr_o[ADDR_W-1 -: HI_W]));

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  localparam int unsigned ADDR_W = 20;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              adv_ni = 1'b1;
  logic              order_i = 1'b1;
  logic [ADDR_W-1:0] addr_o;
  logic [1:0]        step_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;

  // bench model state
  logic [ADDR_W-1:0] m_addr = '0;
  logic [1:0]        m_step = '0;

  always #10 clk_i = ~clk_i;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .addr_i (addr_i),
    .adv_ni (adv_ni),
    .order_i(order_i),
    .addr_o (addr_o),
    .step_o (step_o)
  );

  function automatic logic [ADDR_W-1:0] exp_addr(logic [ADDR_W-1:0] a, logic [1:0] s, logic ord);
    logic [1:0] lo;
    lo = ord ? (a[1:0] ^ s) : 2'(a[1:0] + s);
    return {a[ADDR_W-1:2], lo};
  endfunction

  task automatic check(string tag, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic cycle(logic ld, logic [ADDR_W-1:0] a, logic adv_n, logic ord);
    logic was_load;
    load_i = ld; addr_i = a; adv_ni = adv_n; order_i = ord;
    @(posedge clk_i);
    was_load = ld;
    if (ld) begin m_addr = a; m_step = 2'd0; end
    else if (!adv_n) m_step = m_step + 2'd1;
    @(negedge clk_i);
    if (was_load && !adv_n) check("R9", {18'd0, step_o}, {18'd0, 2'd0});
    else if (was_load)      check("R2", addr_o, m_addr);
    else                    check("R3", {addr_o[ADDR_W-1:2], 2'b00}, {m_addr[ADDR_W-1:2], 2'b00});
    check("R6", {18'd0, step_o}, {18'd0, m_step});
    check(ord ? "R5" : "R4", addr_o, exp_addr(m_addr, m_step, ord));
  endtask

  initial begin : watchdog
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [ADDR_W-1:0] a;
    void'($urandom(32'd1234));
    #5;
    check("R1", addr_o, '0);
    check("R1", {18'd0, step_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", addr_o, '0);

    // every start in both orders, four steps plus wrap (R4, R5, R7)
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        a = {18'h2A5C3, 2'(s)};
        cycle(1'b1, a, 1'b1, 1'(o));
        for (int k = 0; k < 4; k++) cycle(1'b0, '0, 1'b0, 1'(o));
        check("R7", addr_o, a);
      end
    end

    // suspend holds (R6)
    cycle(1'b1, 20'h0F0F1, 1'b1, 1'b0);
    cycle(1'b0, '0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) cycle(1'b0, 20'hFFFFF, 1'b1, 1'b0);
    check("R6", addr_o, 20'h0F0F2);

    // mid-burst and back-to-back loads (R8)
    cycle(1'b0, '0, 1'b0, 1'b1);
    cycle(1'b1, 20'h12347, 1'b1, 1'b1);
    check("R8", addr_o, 20'h12347);
    cycle(1'b1, 20'h55552, 1'b0, 1'b1);
    check("R8", addr_o, 20'h55552);

    // load with advance on same edge (R9)
    cycle(1'b0, '0, 1'b0, 1'b1);
    cycle(1'b1, 20'hABCD1, 1'b0, 1'b0);
    check("R9", addr_o, 20'hABCD1);

    // constrained random
    for (int i = 0; i < 2000; i++) begin
      logic ord;
      ord = ((i / 97) % 2) == 0;
      cycle(($urandom % 5) == 0, ADDR_W'($urandom), 1'($urandom % 3 == 0), ord);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule